// File: doc/BRIEF.md
# Dual-Core Setpoint Transition Controller

This block holds one global operating point, a setpoint numbered 0 to 15, that two processor cores share. Each setpoint names a group of clock settings: which controlled clock sources are powered, and for each clock root which source feeds it and by how much it is divided. Either core asks for a new setpoint with a one-cycle request carrying the target number. The controller accepts one transition at a time, acknowledges the request, and then waits until every core has signalled, through its own completion pulse, that it has finished its part of the change.

Only then does the hardware apply the new settings in a fixed order. Sources the target needs are switched on first. The clock roots move to their new source and divider one cycle later. Sources the target does not use are switched off one cycle after that, in the same cycle as the current-setpoint register takes the new value and the previous-setpoint register takes the old one. The settings table is loaded through a simple write port. A separate always-on oscillator enable sits outside the table and follows only the standby input.

Top module: `sp_xfer_top`

## Requirements
- R1: After reset the current and previous setpoints read 0, busy is low, every controlled source enable is 1, every root select and divider code is 0, and the always-on enable is 1.
- R2: The current setpoint does not change until every core has pulsed its completion input while a transition is pending. Completion pulses given while no transition is pending are not counted.
- R3: Either core may start a transition. When both request in the same cycle, core 0's target wins.
- R4: The cycle after a request is accepted, busy is high and the accepting core's acknowledge is high for one cycle. Busy stays high until the commit.
- R5: While busy, a request for a target other than the pending one gets no acknowledge and does not change the outcome. A request for the pending target is acknowledged.
- R6: After the commit, the controlled source enables equal the enable bits that the target setpoint's table entry holds (bit i drives source i).
- R7: Counting from the edge that samples the last completion pulse: on that edge the target's sources are ORed into the enables. On the next edge the roots change. On the edge after that the unused sources turn off, and the setpoint registers update and busy falls.
- R8: Each root takes the select and divider code from the target's entry. Root r occupies bits [r*2 +: 2] of the select bus and bits [r*3 +: 3] of the divider bus. A divider code N means divide by N+1, so 0 passes the clock and 1 halves it.
- R9: At the commit the previous setpoint takes the value the current setpoint held before it.
- R10: The always-on enable is not part of the table. It is high in every setpoint and goes low the cycle after standby is sampled high.
- R11: A write with index k replaces only entry k. Entries never written keep the reset content: all sources enabled, every select and divider 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 2 | Per-core one-cycle transition request |
| reqTarget | input | 8 | Per-core target setpoint, core c at bits [c*4 +: 4] |
| reqAck | output | 2 | Per-core acknowledge, one cycle after acceptance |
| coreDone | input | 2 | Per-core completion pulse for the pending transition |
| standby | input | 1 | Standby mode; clears the always-on enable |
| wrEn | input | 1 | Table write strobe |
| wrIndex | input | 4 | Setpoint entry to write |
| wrSrcEn | input | 4 | Source enable bits for the entry |
| wrRootSel | input | 4 | Root source selects for the entry |
| wrRootDiv | input | 6 | Root divider codes for the entry |
| srcEn | output | 4 | Controlled clock source enables |
| alwaysOnEn | output | 1 | Always-on oscillator enable |
| rootSel | output | 4 | Clock root source selects |
| rootDiv | output | 6 | Clock root divider codes |
| curSp | output | 4 | Current setpoint |
| prevSp | output | 4 | Previous setpoint |
| busy | output | 1 | Transition pending |

## Verification
Transitions are driven with the completion pulses split across cycles and given together, and each core starts at least once. The split case shows that a single core's completion holds the setpoint, and a stray completion sent while idle is shown not to be counted. Target pairs with overlapping, disjoint and superset source sets tell the on-before-switch and off-after-switch phases apart. Rival requests from the other core, for the same target and for a different one, both in the same cycle and while busy, separate arbitration from the busy-time filter. A move to an entry never written shows the reset table contents.

// File: rtl/sp_xfer_pkg.sv
package sp_xfer_pkg;
  localparam int SP_COUNT = 16;
  localparam int SP_W     = $clog2(SP_COUNT);
  localparam int CORE_N   = 2;
  localparam int SRC_N    = 4;
  localparam int ROOT_N   = 2;
  localparam int SEL_W    = $clog2(SRC_N);
  localparam int DIV_W    = 3;

  typedef struct packed {
    logic [SRC_N-1:0]             srcEn;
    logic [ROOT_N-1:0][SEL_W-1:0] sel;
    logic [ROOT_N-1:0][DIV_W-1:0] div;
  } sp_entry_t;

  typedef struct packed {
    logic capture;
    logic applyRoot;
    logic commit;
  } sp_strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ROOT, ST_OFF} sp_state_t;
endpackage

// File: rtl/sp_xfer_ctrl.sv
module sp_xfer_ctrl
  import sp_xfer_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CORE_N-1:0]      reqValid,
  input  logic [CORE_N*SP_W-1:0] reqTarget,
  input  logic [CORE_N-1:0]      coreDone,
  output logic [CORE_N-1:0]      reqAck,
  output sp_strobe_t             strobe,
  output logic [SP_W-1:0]        tgtSp,
  output logic [SP_W-1:0]        curSp,
  output logic [SP_W-1:0]        prevSp,
  output logic                   busy
);
  sp_state_t state;
  logic [CORE_N-1:0][SP_W-1:0] reqTgtArr;
  logic [CORE_N-1:0] doneSeen;
  logic [CORE_N-1:0] doneNow;
  logic [CORE_N-1:0] ackNext;
  logic [SP_W-1:0]   winTgt;
  logic              allDone;

  assign reqTgtArr = reqTarget;
  assign doneNow   = doneSeen | coreDone;
  assign allDone   = &doneNow;
  assign busy      = (state != ST_IDLE);

  // lowest-numbered requester wins
  always_comb begin
    winTgt = '0;
    for (int i = CORE_N - 1; i >= 0; i--) begin
      if (reqValid[i]) winTgt = reqTgtArr[i];
    end
  end

  always_comb begin
    for (int i = 0; i < CORE_N; i++) begin
      ackNext[i] = reqValid[i] &&
                   ((state == ST_IDLE) ? (reqTgtArr[i] == winTgt)
                                       : (reqTgtArr[i] == tgtSp));
    end
  end

  always_comb begin
    strobe.capture   = (state == ST_WAIT) && allDone;
    strobe.applyRoot = (state == ST_ROOT);
    strobe.commit    = (state == ST_OFF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tgtSp    <= '0;
      curSp    <= '0;
      prevSp   <= '0;
      doneSeen <= '0;
      reqAck   <= '0;
    end else begin
      reqAck <= ackNext;
      unique case (state)
        ST_IDLE: begin
          doneSeen <= '0;
          if (|reqValid) begin
            tgtSp <= winTgt;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          doneSeen <= doneNow;
          if (allDone) state <= ST_ROOT;
        end
        ST_ROOT: state <= ST_OFF;
        ST_OFF: begin
          prevSp   <= curSp;
          curSp    <= tgtSp;
          doneSeen <= '0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CUR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(curSp)); // R2
  AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (prevSp == $past(curSp))); // R9
  AST_TGT_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.commit) |=> $stable(tgtSp)); // R5
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && |reqValid) |=> busy); // R4
endmodule

// File: rtl/sp_xfer_path.sv
module sp_xfer_path
  import sp_xfer_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  sp_strobe_t                   strobe,
  input  logic [SP_W-1:0]              tgtSp,
  input  logic                         standby,
  input  logic                         wrEn,
  input  logic [SP_W-1:0]              wrIndex,
  input  sp_entry_t                    wrEntry,
  output logic [SRC_N-1:0]             srcEn,
  output logic                         alwaysOnEn,
  output logic [ROOT_N-1:0][SEL_W-1:0] rootSel,
  output logic [ROOT_N-1:0][DIV_W-1:0] rootDiv
);
  localparam sp_entry_t RST_ENTRY = '{srcEn: {SRC_N{1'b1}}, sel: '0, div: '0};

  sp_entry_t tbl [SP_COUNT];
  sp_entry_t shadow;
  sp_entry_t tblRd;

  for (genvar e = 0; e < SP_COUNT; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)                                  tbl[e] <= RST_ENTRY;
      else if (wrEn && (wrIndex == SP_W'(e)))     tbl[e] <= wrEntry;
    end
  end

  assign tblRd = tbl[tgtSp];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow     <= RST_ENTRY;
      srcEn      <= {SRC_N{1'b1}};
      rootSel    <= '0;
      rootDiv    <= '0;
      alwaysOnEn <= 1'b1;
    end else begin
      alwaysOnEn <= !standby;
      if (strobe.capture) begin
        shadow <= tblRd;
        srcEn  <= srcEn | tblRd.srcEn;
      end
      if (strobe.applyRoot) begin
        rootSel <= shadow.sel;
        rootDiv <= shadow.div;
      end
      if (strobe.commit) srcEn <= shadow.srcEn;
    end
  end

  AST_ON_BEFORE_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.applyRoot |-> ((srcEn & shadow.srcEn) == shadow.srcEn)); // R7
  AST_ROOTS_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (rootSel == shadow.sel && rootDiv == shadow.div)); // R7
  AST_CAPTURE_ONLY_ADDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> ((srcEn & $past(srcEn)) == $past(srcEn))); // R7
  AST_AON_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> !alwaysOnEn); // R10
  AST_AON_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !standby |=> alwaysOnEn); // R10
endmodule

// File: rtl/sp_xfer_top.sv
module sp_xfer_top
  import sp_xfer_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CORE_N-1:0]        reqValid,
  input  logic [CORE_N*SP_W-1:0]   reqTarget,
  output logic [CORE_N-1:0]        reqAck,
  input  logic [CORE_N-1:0]        coreDone,
  input  logic                     standby,
  input  logic                     wrEn,
  input  logic [SP_W-1:0]          wrIndex,
  input  logic [SRC_N-1:0]         wrSrcEn,
  input  logic [ROOT_N*SEL_W-1:0]  wrRootSel,
  input  logic [ROOT_N*DIV_W-1:0]  wrRootDiv,
  output logic [SRC_N-1:0]         srcEn,
  output logic                     alwaysOnEn,
  output logic [ROOT_N*SEL_W-1:0]  rootSel,
  output logic [ROOT_N*DIV_W-1:0]  rootDiv,
  output logic [SP_W-1:0]          curSp,
  output logic [SP_W-1:0]          prevSp,
  output logic                     busy
);
  sp_strobe_t                   strobe;
  logic [SP_W-1:0]              tgtSp;
  sp_entry_t                    wrEntry;
  logic [ROOT_N-1:0][SEL_W-1:0] selArr;
  logic [ROOT_N-1:0][DIV_W-1:0] divArr;

  assign wrEntry.srcEn = wrSrcEn;
  assign wrEntry.sel   = wrRootSel;
  assign wrEntry.div   = wrRootDiv;
  assign rootSel       = selArr;
  assign rootDiv       = divArr;

  sp_xfer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqTarget (reqTarget),
    .coreDone  (coreDone),
    .reqAck    (reqAck),
    .strobe    (strobe),
    .tgtSp     (tgtSp),
    .curSp     (curSp),
    .prevSp    (prevSp),
    .busy      (busy)
  );

  sp_xfer_path u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .tgtSp      (tgtSp),
    .standby    (standby),
    .wrEn       (wrEn),
    .wrIndex    (wrIndex),
    .wrEntry    (wrEntry),
    .srcEn      (srcEn),
    .alwaysOnEn (alwaysOnEn),
    .rootSel    (selArr),
    .rootDiv    (divArr)
  );
endmodule

// File: tb/sp_xfer_top_test.sv
module sp_xfer_top_test;
  import sp_xfer_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CORE_N-1:0]       reqValid = '0;
  logic [CORE_N*SP_W-1:0]  reqTarget = '0;
  logic [CORE_N-1:0]       reqAck;
  logic [CORE_N-1:0]       coreDone = '0;
  logic                    standby = 1'b0;
  logic                    wrEn = 1'b0;
  logic [SP_W-1:0]         wrIndex = '0;
  logic [SRC_N-1:0]        wrSrcEn = '0;
  logic [ROOT_N*SEL_W-1:0] wrRootSel = '0;
  logic [ROOT_N*DIV_W-1:0] wrRootDiv = '0;
  logic [SRC_N-1:0]        srcEn;
  logic                    alwaysOnEn;
  logic [ROOT_N*SEL_W-1:0] rootSel;
  logic [ROOT_N*DIV_W-1:0] rootDiv;
  logic [SP_W-1:0]         curSp, prevSp;
  logic                    busy;

  always #10 clk = ~clk; // 50 MHz

  sp_xfer_top uut (.*);

  typedef struct {
    int                      due;
    int                      tag;
    logic [SRC_N-1:0]        src;
    logic [ROOT_N*SEL_W-1:0] sel;
    logic [ROOT_N*DIV_W-1:0] div;
    logic [SP_W-1:0]         cur;
    logic [SP_W-1:0]         prev;
    logic                    bsy;
  } exp_t;

  exp_t q[$];
  exp_t itM;
  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  bit ended = 0;

  // bench model of the table and outputs
  logic [SRC_N-1:0]        mTblSrc [SP_COUNT];
  logic [ROOT_N*SEL_W-1:0] mTblSel [SP_COUNT];
  logic [ROOT_N*DIV_W-1:0] mTblDiv [SP_COUNT];
  logic [SRC_N-1:0]        mSrc;
  logic [ROOT_N*SEL_W-1:0] mSel;
  logic [ROOT_N*DIV_W-1:0] mDiv;
  logic [SP_W-1:0]         mCur, mPrev;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input int tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // monitor: pops expected items as their cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      itM = q.pop_front();
      check(itM.tag, "srcEn", 32'(srcEn), 32'(itM.src));
      check(itM.tag, "rootSel", 32'(rootSel), 32'(itM.sel));
      check(itM.tag, "rootDiv", 32'(rootDiv), 32'(itM.div));
      check(itM.tag, "curSp", 32'(curSp), 32'(itM.cur));
      check(itM.tag, "prevSp", 32'(prevSp), 32'(itM.prev));
      check(itM.tag, "busy", 32'(busy), 32'(itM.bsy));
      check(10, "alwaysOnEn", 32'(alwaysOnEn), 32'd1); // R10
    end
  end

  task automatic push(input int dly, input int tag, input logic [SRC_N-1:0] s,
                      input logic [ROOT_N*SEL_W-1:0] se, input logic [ROOT_N*DIV_W-1:0] d,
                      input logic [SP_W-1:0] c, input logic [SP_W-1:0] p, input logic b);
    exp_t e;
    e.due = cyc + dly; e.tag = tag; e.src = s; e.sel = se; e.div = d;
    e.cur = c; e.prev = p; e.bsy = b;
    q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic writeEntry(input int idx, input logic [SRC_N-1:0] s,
                            input logic [ROOT_N*SEL_W-1:0] se, input logic [ROOT_N*DIV_W-1:0] d);
    wrEn = 1; wrIndex = SP_W'(idx); wrSrcEn = s; wrRootSel = se; wrRootDiv = d;
    step();
    wrEn = 0;
    mTblSrc[idx] = s; mTblSel[idx] = se; mTblDiv[idx] = d;
  endtask

  // rivalMode: 0 none, 1 rival requests in the same cycle, 2 rival requests while busy
  task automatic runXfer(input int starter, input int tgt, input bit splitDone,
                         input int rivalMode, input int rivalTgt);
    int rival;
    logic [SRC_N-1:0] tS;
    rival = 1 - starter;
    reqValid = '0;
    reqValid[starter] = 1'b1;
    reqTarget[starter*SP_W +: SP_W] = SP_W'(tgt);
    if (rivalMode == 1) begin
      reqValid[rival] = 1'b1;
      reqTarget[rival*SP_W +: SP_W] = SP_W'(rivalTgt);
    end
    step();
    reqValid = '0;
    check(4, "ack of starter", 32'(reqAck[starter]), 32'd1); // R4
    check(4, "busy after accept", 32'(busy), 32'd1);         // R4
    check(2, "curSp after request", 32'(curSp), 32'(mCur));  // R2
    if (rivalMode == 1)
      check(3, "ack of rival same cycle", 32'(reqAck[rival]), 32'(rivalTgt == tgt)); // R3
    if (rivalMode == 2) begin
      reqValid[rival] = 1'b1;
      reqTarget[rival*SP_W +: SP_W] = SP_W'(rivalTgt);
      step();
      reqValid = '0;
      check(5, "ack of rival while busy", 32'(reqAck[rival]), 32'(rivalTgt == tgt)); // R5
      check(5, "busy while rival", 32'(busy), 32'd1); // R5
    end
    if (splitDone) begin
      coreDone = '0;
      coreDone[starter] = 1'b1;
      step();
      coreDone = '0;
      step();
      check(2, "curSp after one done", 32'(curSp), 32'(mCur));   // R2
      check(2, "srcEn after one done", 32'(srcEn), 32'(mSrc));   // R2
      check(2, "busy after one done", 32'(busy), 32'd1);         // R2
      coreDone[rival] = 1'b1;
    end else begin
      coreDone = '1;
    end
    tS = mTblSrc[tgt];
    push(1, 7, mSrc | tS, mSel, mDiv, mCur, mPrev, 1'b1);                       // R7
    push(2, 8, mSrc | tS, mTblSel[tgt], mTblDiv[tgt], mCur, mPrev, 1'b1);       // R8
    push(3, 6, tS, mTblSel[tgt], mTblDiv[tgt], SP_W'(tgt), mCur, 1'b0);         // R6 R9
    step();
    coreDone = '0;
    step(); step(); step();
    mPrev = mCur; mCur = SP_W'(tgt);
    mSrc = tS; mSel = mTblSel[tgt]; mDiv = mTblDiv[tgt];
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < SP_COUNT; i++) begin
      mTblSrc[i] = '1; mTblSel[i] = '0; mTblDiv[i] = '0;
    end
    mSrc = '1; mSel = '0; mDiv = '0; mCur = '0; mPrev = '0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    check(1, "curSp reset", 32'(curSp), 32'd0);
    check(1, "prevSp reset", 32'(prevSp), 32'd0);
    check(1, "busy reset", 32'(busy), 32'd0);
    check(1, "srcEn reset", 32'(srcEn), 32'hF);
    check(1, "rootSel reset", 32'(rootSel), 32'd0);
    check(1, "rootDiv reset", 32'(rootDiv), 32'd0);
    check(1, "alwaysOnEn reset", 32'(alwaysOnEn), 32'd1);

    // R11 table writes; R8 field layout root0 low
    writeEntry(5, 4'b0011, 4'b00_01, 6'b011_001);
    writeEntry(9, 4'b1100, 4'b11_10, 6'b010_000);
    writeEntry(1, 4'b0101, 4'b10_00, 6'b111_100);
    check(11, "write leaves outputs", 32'(srcEn), 32'hF); // R11

    // R2 R3: core 0 starts, completions split
    runXfer(0, 5, 1'b1, 0, 0);
    // R3 R5: core 1 starts, core 0 asks for other target while busy
    runXfer(1, 9, 1'b0, 2, 1);
    // R2: stray completion while idle is not counted
    coreDone = 2'b10;
    step();
    coreDone = '0;
    step();
    check(2, "idle done keeps idle", 32'(busy), 32'd0);
    // R5: same target while busy is acknowledged
    runXfer(0, 1, 1'b1, 2, 1);
    // R3 R11: same-cycle conflict, core 0 wins, unwritten entry 12
    runXfer(0, 12, 1'b0, 1, 9);
    check(11, "unwritten entry sources", 32'(srcEn), 32'hF);
    check(11, "unwritten entry divider", 32'(rootDiv), 32'd0);
    // R3: core 1 starts with core 0 asking for the same target
    runXfer(1, 5, 1'b1, 1, 5);

    // R10 standby
    standby = 1'b1;
    step();
    check(10, "alwaysOnEn in standby", 32'(alwaysOnEn), 32'd0);
    check(10, "srcEn untouched by standby", 32'(srcEn), 32'(mSrc));
    standby = 1'b0;
    step();
    check(10, "alwaysOnEn after standby", 32'(alwaysOnEn), 32'd1);
    step();
    report();
  end
endmodule